// File: doc/BRIEF.md
# SDRAM Read-Burst Precharge Sequencer

This block drives the command, address and bank lines of one SDRAM bank for a single read access. A request carries a bank, row, column, wanted beat count, burst mode and a precharge scope. The block opens the row with ACTIVE. After a row-to-column delay it issues READ with auto precharge disabled. It then closes the row with an early PRECHARGE placed so that the row precharge time runs while the last data beats are still coming back.

The PRECHARGE lands CAS-latency-minus-one cycles before the cycle in which the last wanted beat is valid. As a result it always falls N cycles after the READ, whatever the latency. A short request truncates a four-beat burst. A full-page request uses PRECHARGE as its only terminator. A four-beat request closes the row exactly where auto precharge would. A read-data-valid strobe with a beat index marks each returning beat. After PRECHARGE, the request-ready output stays low until the precharge time has run.

Top module: `rdburst_pre_seq`

## Requirements
- R1: Commands are coded {CS_n, RAS_n, CAS_n, WE_n} with NOP = 4'b0111, ACTIVE = 4'b0011, READ = 4'b0101 and PRECHARGE = 4'b0010. An accepted request produces ACTIVE in the next cycle, with the row on the address lines and the request bank on the bank lines.
- R2: READ follows ACTIVE by exactly TRCD cycles. It carries the column in the low address bits, address bit 10 low (no auto precharge) and the same bank.
- R3: With N effective beats, PRECHARGE appears exactly N cycles after READ for every CAS latency. Every other cycle of the access carries NOP.
- R4: Beat k (k = 0 .. N-1) is flagged by the read-valid strobe in cycle READ + CL + k, with beat index k. This includes beats that arrive after PRECHARGE has been issued, for CL of 1, 2 and 3.
- R5: In fixed mode (full-page input low), a beat count above 4 is clamped to 4. A count of 0 is treated as 1 in either mode.
- R6: In full-page mode, any count up to 2^COL_W beats is honoured, and the burst is ended only by the PRECHARGE.
- R7: On PRECHARGE, address bit 10 equals the request's all-banks flag and every other address bit is 0.
- R8: Request-ready is low from acceptance until TRP-1 cycles after PRECHARGE. A request offered while ready is low is not taken, so ACTIVE never comes sooner than TRP cycles after PRECHARGE.
- R9: DQM is low from the READ cycle through the cycle of the last beat, and high at all other times.
- R10: While reset is high and in the first cycle after it, the command is NOP, ready is high, the read-valid strobe is low and DQM is high. A reset in the middle of a burst abandons it.
- R11: CAS latency, bank, row, column, beat count and mode are captured at acceptance. Later changes on those inputs do not affect the access in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| req_valid_i | input | 1 | Read request offered |
| req_ready_o | output | 1 | Request can be taken this cycle |
| req_bank_i | input | BANK_W | Bank of the access |
| req_row_i | input | ROW_W | Row to open |
| req_col_i | input | COL_W | Starting column |
| req_beats_i | input | COL_W+1 | Wanted beat count |
| req_full_page_i | input | 1 | 1 = full-page burst, 0 = four-beat burst |
| req_pre_all_i | input | 1 | PRECHARGE targets all banks |
| cas_lat_i | input | 2 | CAS latency, 1 to 3 |
| cmd_o | output | 4 | {CS_n, RAS_n, CAS_n, WE_n} |
| addr_o | output | ADDR_W | SDRAM address lines |
| ba_o | output | BANK_W | SDRAM bank lines |
| dqm_o | output | 1 | Data mask, low while reading |
| rd_valid_o | output | 1 | A read beat is valid this cycle |
| rd_beat_o | output | COL_W | Index of that beat |

## Verification
The properties assume that the CAS latency presented at acceptance is 1, 2 or 3. They also assume that reset is asserted from time zero. Latency 0 is undefined and produces no strobe. The stimulus only offers latencies from that set. It holds reset high for the first cycles. It then drives the request lines with different values straight after acceptance, so that only captured values can yield the expected outputs. It also offers requests during the precharge lockout, which the design has to ignore.

// File: rtl/rdbp_pkg.sv
package rdbp_pkg;
  typedef enum logic [3:0] {
    CMD_NOP = 4'b0111,
    CMD_ACT = 4'b0011,
    CMD_RD  = 4'b0101,
    CMD_PRE = 4'b0010
  } sd_cmd_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_RCD,
    ST_BURST
  } seq_state_e;

  localparam int FIXED_BL = 4;
  localparam int CL_MAX   = 3;
  localparam int CL_W     = $clog2(CL_MAX + 1);
  localparam int AP_BIT   = 10;
endpackage

// File: rtl/rdbp_cmd_fsm.sv
module rdbp_cmd_fsm
  import rdbp_pkg::*;
#(
  parameter int BANK_W = 2,
  parameter int ROW_W  = 13,
  parameter int COL_W  = 9,
  parameter int ADDR_W = 13,
  parameter int TRCD   = 2,
  parameter int TRP    = 3
) (
  input  logic                clk_i,
  input  logic                rst_i,
  input  logic                req_valid_i,
  output logic                req_ready_o,
  input  logic [BANK_W-1:0]   req_bank_i,
  input  logic [ROW_W-1:0]    req_row_i,
  input  logic [COL_W-1:0]    req_col_i,
  input  logic [COL_W:0]      req_beats_i,
  input  logic                req_full_page_i,
  input  logic                req_pre_all_i,
  input  logic [CL_W-1:0]     cas_lat_i,
  output logic [3:0]          cmd_o,
  output logic [ADDR_W-1:0]   addr_o,
  output logic [BANK_W-1:0]   ba_o,
  output logic                tok_valid_o,
  output logic [COL_W-1:0]    tok_idx_o,
  output logic [CL_W-1:0]     tok_cl_o
);
  localparam int BEATS_W = COL_W + 1;
  localparam int TRCD_W  = $clog2(TRCD + 1);
  localparam int TRP_W   = $clog2(TRP + 1);
  localparam logic [BEATS_W-1:0] PAGE_BEATS = BEATS_W'(1 << COL_W);

  seq_state_e           state_q;
  sd_cmd_e              cmd_q;
  logic [ADDR_W-1:0]    addr_q;
  logic [BANK_W-1:0]    ba_q;
  logic [TRCD_W-1:0]    rcd_q;
  logic [TRP_W-1:0]     trp_q;
  logic [BEATS_W-1:0]   rem_q;
  logic [COL_W-1:0]     idx_q;
  logic [COL_W-1:0]     col_q;
  logic [CL_W-1:0]      cl_q;
  logic                 pre_all_q;
  logic [BEATS_W-1:0]   n_eff;
  logic [ADDR_W-1:0]    col_addr;
  logic [ADDR_W-1:0]    pre_addr;
  logic                 accept;

  // effective beat count: zero means one, fixed mode stops at four, page at 2^COL_W
  always_comb begin
    n_eff = req_beats_i;
    if (n_eff == '0) n_eff = BEATS_W'(1);
    if (!req_full_page_i && n_eff > BEATS_W'(FIXED_BL)) n_eff = BEATS_W'(FIXED_BL);
    if (n_eff > PAGE_BEATS) n_eff = PAGE_BEATS;
  end

  always_comb begin
    col_addr = '0;
    col_addr[COL_W-1:0] = col_q;
    col_addr[AP_BIT] = 1'b0;
    pre_addr = '0;
    pre_addr[AP_BIT] = pre_all_q;
  end

  assign req_ready_o = (state_q == ST_IDLE) && (trp_q == '0);
  assign accept      = req_valid_i && req_ready_o;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      state_q   <= ST_IDLE;
      cmd_q     <= CMD_NOP;
      addr_q    <= '0;
      ba_q      <= '0;
      rcd_q     <= '0;
      trp_q     <= '0;
      rem_q     <= '0;
      idx_q     <= '0;
      col_q     <= '0;
      cl_q      <= '0;
      pre_all_q <= 1'b0;
    end else begin
      cmd_q  <= CMD_NOP;
      addr_q <= '0;
      if (trp_q != '0) trp_q <= trp_q - 1'b1;
      case (state_q)
        ST_IDLE: begin
          if (accept) begin
            cmd_q     <= CMD_ACT;
            addr_q    <= ADDR_W'(req_row_i);
            ba_q      <= req_bank_i;
            col_q     <= req_col_i;
            cl_q      <= cas_lat_i;
            pre_all_q <= req_pre_all_i;
            rem_q     <= n_eff - 1'b1;
            rcd_q     <= TRCD_W'(TRCD - 1);
            state_q   <= ST_RCD;
          end
        end
        ST_RCD: begin
          if (rcd_q == '0) begin
            cmd_q   <= CMD_RD;
            addr_q  <= col_addr;
            idx_q   <= '0;
            state_q <= ST_BURST;
          end else begin
            rcd_q <= rcd_q - 1'b1;
          end
        end
        ST_BURST: begin
          idx_q <= idx_q + 1'b1;
          if (rem_q == '0) begin
            cmd_q   <= CMD_PRE;
            addr_q  <= pre_addr;
            trp_q   <= TRP_W'(TRP - 1);
            state_q <= ST_IDLE;
          end else begin
            rem_q <= rem_q - 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign cmd_o       = cmd_q;
  assign addr_o      = addr_q;
  assign ba_o        = ba_q;
  assign tok_valid_o = (state_q == ST_BURST);
  assign tok_idx_o   = idx_q;
  assign tok_cl_o    = cl_q;
endmodule

// File: rtl/rdbp_beat_pipe.sv
module rdbp_beat_pipe
  import rdbp_pkg::*;
#(
  parameter int COL_W = 9
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              tok_valid_i,
  input  logic [COL_W-1:0]  tok_idx_i,
  input  logic [CL_W-1:0]   tok_cl_i,
  output logic              rd_valid_o,
  output logic [COL_W-1:0]  rd_beat_o,
  output logic              busy_o
);
  logic [CL_MAX:1]  v_q;
  logic [COL_W-1:0] idx_q [1:CL_MAX];
  logic [CL_W-1:0]  cl_q  [1:CL_MAX];
  logic [CL_MAX:1]  hit;

  // a token moves one stage per cycle and leaves once it reaches its own latency
  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      v_q <= '0;
    end else begin
      v_q[1] <= tok_valid_i;
      for (int s = 2; s <= CL_MAX; s++)
        v_q[s] <= v_q[s-1] && (cl_q[s-1] != CL_W'(s-1));
    end
    idx_q[1] <= tok_idx_i;
    cl_q[1]  <= tok_cl_i;
    for (int s = 2; s <= CL_MAX; s++) begin
      idx_q[s] <= idx_q[s-1];
      cl_q[s]  <= cl_q[s-1];
    end
  end

  for (genvar s = 1; s <= CL_MAX; s++) begin : g_hit
    assign hit[s] = v_q[s] && (cl_q[s] == CL_W'(s));
  end

  always_comb begin
    rd_beat_o = '0;
    for (int s = 1; s <= CL_MAX; s++)
      if (hit[s]) rd_beat_o = idx_q[s];
  end

  assign rd_valid_o = |hit;
  assign busy_o     = |v_q;
endmodule

// File: rtl/rdburst_pre_seq.sv
module rdburst_pre_seq
  import rdbp_pkg::*;
#(
  parameter int BANK_W = 2,
  parameter int ROW_W  = 13,
  parameter int COL_W  = 9,
  parameter int ADDR_W = 13,
  parameter int TRCD   = 2,
  parameter int TRP    = 3
) (
  input  logic               clk_i,
  input  logic               rst_i,
  input  logic               req_valid_i,
  output logic               req_ready_o,
  input  logic [BANK_W-1:0]  req_bank_i,
  input  logic [ROW_W-1:0]   req_row_i,
  input  logic [COL_W-1:0]   req_col_i,
  input  logic [COL_W:0]     req_beats_i,
  input  logic               req_full_page_i,
  input  logic               req_pre_all_i,
  input  logic [1:0]         cas_lat_i,
  output logic [3:0]         cmd_o,
  output logic [ADDR_W-1:0]  addr_o,
  output logic [BANK_W-1:0]  ba_o,
  output logic               dqm_o,
  output logic               rd_valid_o,
  output logic [COL_W-1:0]   rd_beat_o
);
  logic              tok_valid;
  logic [COL_W-1:0]  tok_idx;
  logic [CL_W-1:0]   tok_cl;
  logic              pipe_busy;

  rdbp_cmd_fsm #(
    .BANK_W(BANK_W), .ROW_W(ROW_W), .COL_W(COL_W),
    .ADDR_W(ADDR_W), .TRCD(TRCD), .TRP(TRP)
  ) u_fsm (
    .clk_i           (clk_i),
    .rst_i           (rst_i),
    .req_valid_i     (req_valid_i),
    .req_ready_o     (req_ready_o),
    .req_bank_i      (req_bank_i),
    .req_row_i       (req_row_i),
    .req_col_i       (req_col_i),
    .req_beats_i     (req_beats_i),
    .req_full_page_i (req_full_page_i),
    .req_pre_all_i   (req_pre_all_i),
    .cas_lat_i       (cas_lat_i),
    .cmd_o           (cmd_o),
    .addr_o          (addr_o),
    .ba_o            (ba_o),
    .tok_valid_o     (tok_valid),
    .tok_idx_o       (tok_idx),
    .tok_cl_o        (tok_cl)
  );

  rdbp_beat_pipe #(.COL_W(COL_W)) u_pipe (
    .clk_i       (clk_i),
    .rst_i       (rst_i),
    .tok_valid_i (tok_valid),
    .tok_idx_i   (tok_idx),
    .tok_cl_i    (tok_cl),
    .rd_valid_o  (rd_valid_o),
    .rd_beat_o   (rd_beat_o),
    .busy_o      (pipe_busy)
  );

  // mask released only while a read is being issued or its beats are in flight
  assign dqm_o = !(tok_valid || pipe_busy);
endmodule

// File: rtl/rdburst_pre_seq_chk.sv
module rdburst_pre_seq_chk #(
  parameter int ADDR_W = 13,
  parameter int COL_W  = 9,
  parameter int TRP    = 3
) (
  input logic              clk_i,
  input logic              rst_i,
  input logic [3:0]        cmd_o,
  input logic [ADDR_W-1:0] addr_o,
  input logic              req_ready_o,
  input logic              dqm_o,
  input logic              rd_valid_o,
  input logic [COL_W-1:0]  rd_beat_o
);
  localparam int GAP_W = $clog2(TRP + 1) + 1;
  logic [GAP_W-1:0] since_pre;

  always_ff @(posedge clk_i) begin
    if (rst_i) since_pre <= GAP_W'(TRP);
    else if (cmd_o == 4'b0010) since_pre <= GAP_W'(1);
    else if (since_pre < GAP_W'(TRP)) since_pre <= since_pre + 1'b1;
  end

  AST_CMD_LEGAL: assert property (@(posedge clk_i) disable iff (rst_i)
    (cmd_o == 4'b0111 || cmd_o == 4'b0011 || cmd_o == 4'b0101 || cmd_o == 4'b0010)); // R1
  AST_READ_NO_AP: assert property (@(posedge clk_i) disable iff (rst_i)
    (cmd_o == 4'b0101) |-> (addr_o[10] == 1'b0)); // R2
  AST_TRP_GAP: assert property (@(posedge clk_i) disable iff (rst_i)
    (cmd_o == 4'b0011) |-> (since_pre >= GAP_W'(TRP))); // R8
  AST_READY_QUIET: assert property (@(posedge clk_i) disable iff (rst_i)
    req_ready_o |-> (cmd_o != 4'b0011 && cmd_o != 4'b0101)); // R8
  AST_DQM_OPEN: assert property (@(posedge clk_i) disable iff (rst_i)
    rd_valid_o |-> !dqm_o); // R9
  AST_BEAT_STEP: assert property (@(posedge clk_i) disable iff (rst_i)
    (rd_valid_o && $past(rd_valid_o) && rd_beat_o != '0) |-> (rd_beat_o == $past(rd_beat_o) + 1'b1)); // R4
  AST_RESET_IDLE: assert property (@(posedge clk_i)
    rst_i |=> (cmd_o == 4'b0111 && !rd_valid_o && dqm_o)); // R10
endmodule

bind rdburst_pre_seq rdburst_pre_seq_chk #(
  .ADDR_W(ADDR_W), .COL_W(COL_W), .TRP(TRP)
) u_chk (
  .clk_i       (clk_i),
  .rst_i       (rst_i),
  .cmd_o       (cmd_o),
  .addr_o      (addr_o),
  .req_ready_o (req_ready_o),
  .dqm_o       (dqm_o),
  .rd_valid_o  (rd_valid_o),
  .rd_beat_o   (rd_beat_o)
);

// File: tb/rdburst_pre_seq_test.sv
`timescale 1ns/1ps
module rdburst_pre_seq_test;
  localparam int BANK_W = 2;
  localparam int ROW_W  = 13;
  localparam int COL_W  = 9;
  localparam int ADDR_W = 13;
  localparam int TRCD   = 2;
  localparam int TRP    = 3;
  localparam int NVEC   = 10;

  // {cl[2], full_page[1], beats[10], pre_all[1], bank[2], row[13], col[9]}
  localparam logic [37:0] VEC [NVEC] = '{
    {2'd1, 1'b0, 10'd4,  1'b0, 2'd0, 13'h0123, 9'h010},
    {2'd2, 1'b0, 10'd4,  1'b0, 2'd1, 13'h1A5C, 9'h0F0},
    {2'd3, 1'b0, 10'd4,  1'b1, 2'd2, 13'h0777, 9'h1FC},
    {2'd3, 1'b0, 10'd1,  1'b0, 2'd3, 13'h1001, 9'h003},
    {2'd2, 1'b0, 10'd2,  1'b1, 2'd0, 13'h0ABC, 9'h155},
    {2'd1, 1'b0, 10'd3,  1'b1, 2'd1, 13'h1FFF, 9'h0AA},
    {2'd3, 1'b0, 10'd7,  1'b0, 2'd2, 13'h0042, 9'h100},
    {2'd2, 1'b0, 10'd0,  1'b0, 2'd3, 13'h0B0B, 9'h020},
    {2'd3, 1'b1, 10'd20, 1'b0, 2'd1, 13'h1234, 9'h000},
    {2'd1, 1'b1, 10'd9,  1'b1, 2'd0, 13'h0F0F, 9'h1E0}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [BANK_W-1:0] req_bank = '0;
  logic [ROW_W-1:0]  req_row = '0;
  logic [COL_W-1:0]  req_col = '0;
  logic [COL_W:0]    req_beats = '0;
  logic req_fp = 1'b0;
  logic req_pa = 1'b0;
  logic [1:0] cas_lat = 2'd1;
  logic [3:0] cmd;
  logic [ADDR_W-1:0] addr;
  logic [BANK_W-1:0] ba;
  logic dqm, rd_valid;
  logic [COL_W-1:0] rd_beat;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  rdburst_pre_seq #(
    .BANK_W(BANK_W), .ROW_W(ROW_W), .COL_W(COL_W),
    .ADDR_W(ADDR_W), .TRCD(TRCD), .TRP(TRP)
  ) uut (
    .clk_i(clk), .rst_i(rst), .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_bank_i(req_bank), .req_row_i(req_row), .req_col_i(req_col),
    .req_beats_i(req_beats), .req_full_page_i(req_fp), .req_pre_all_i(req_pa),
    .cas_lat_i(cas_lat), .cmd_o(cmd), .addr_o(addr), .ba_o(ba), .dqm_o(dqm),
    .rd_valid_o(rd_valid), .rd_beat_o(rd_beat)
  );

  task automatic chk(input bit ok, input string rq, input string what, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s @%0t: actual %0d expected %0d", rq, what, $time, act, exp);
    end
  endtask

  task automatic check_idle(input string rq);
    chk(cmd == 4'b0111, rq, "cmd idle", int'(cmd), 7);
    chk(req_ready == 1'b1, rq, "ready idle", int'(req_ready), 1);
    chk(rd_valid == 1'b0, rq, "valid idle", int'(rd_valid), 0);
    chk(dqm == 1'b1, rq, "dqm idle", int'(dqm), 1);
  endtask

  task automatic run_req(input logic [1:0] cl, input logic fp, input logic [9:0] nb,
                         input logic pa, input logic [1:0] bk, input logic [12:0] row,
                         input logic [8:0] col);
    int neff, tr, tp, tlast, tend, nbeats;
    logic [3:0] ecmd;
    string crq;
    neff = (nb == 0) ? 1 : int'(nb);
    if (!fp && neff > 4) neff = 4;
    while (req_ready !== 1'b1) @(negedge clk);
    cas_lat = cl; req_fp = fp; req_beats = nb; req_pa = pa;
    req_bank = bk; req_row = row; req_col = col; req_valid = 1'b1;
    @(negedge clk);
    // scramble every request input: only captured values may matter (R11)
    req_valid = 1'b0; cas_lat = 2'd0; req_fp = ~fp; req_beats = ~nb;
    req_pa = ~pa; req_bank = ~bk; req_row = ~row; req_col = ~col;
    tr = 1 + TRCD;
    tp = tr + neff;
    tlast = tr + int'(cl) + neff - 1;
    tend = ((tp + TRP - 1) > tlast ? (tp + TRP - 1) : tlast) + 1;
    nbeats = 0;
    for (int t = 1; t <= tend; t++) begin
      if (t == 1)       begin ecmd = 4'b0011; crq = "R1"; end
      else if (t == tr) begin ecmd = 4'b0101; crq = "R2"; end
      else if (t == tp) begin ecmd = 4'b0010; crq = "R3"; end
      else              begin ecmd = 4'b0111; crq = (t > tp) ? "R8" : "R3"; end
      chk(cmd == ecmd, crq, "command", int'(cmd), int'(ecmd));
      if (t == 1) begin
        chk(addr == ADDR_W'(row), "R1", "row addr", int'(addr), int'(row));
        chk(ba == bk, "R1", "act bank", int'(ba), int'(bk));
      end
      if (t == tr) begin
        chk(addr == ADDR_W'(col), "R2", "col addr/A10", int'(addr), int'(col));
        chk(ba == bk, "R2", "read bank", int'(ba), int'(bk));
      end
      if (t == tp)
        chk(addr == (ADDR_W'(pa) << 10), "R7", "pre addr", int'(addr), int'(pa) << 10);
      if (t >= tr + int'(cl) && t <= tlast) begin
        chk(rd_valid == 1'b1, "R4/R11", "valid", int'(rd_valid), 1);
        chk(int'(rd_beat) == t - tr - int'(cl), "R4/R11", "beat idx", int'(rd_beat), t - tr - int'(cl));
      end else begin
        chk(rd_valid == 1'b0, "R4/R11", "valid off", int'(rd_valid), 0);
      end
      if (rd_valid) nbeats++;
      chk(dqm == !(t >= tr && t <= tlast), "R9", "dqm", int'(dqm), int'(!(t >= tr && t <= tlast)));
      chk(req_ready == (t >= tp + TRP - 1), "R8", "ready", int'(req_ready), int'(t >= tp + TRP - 1));
      // offer a request during the precharge lockout; it must be ignored (R8)
      req_valid = (t + 1 >= tp) && (t + 1 <= tp + TRP - 2);
      @(negedge clk);
    end
    req_valid = 1'b0;
    if (fp) chk(nbeats == neff, "R6", "page beats", nbeats, neff);
    else    chk(nbeats == neff, "R5", "fixed beats", nbeats, neff);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check_idle("R10");
    rst = 1'b0;
    @(negedge clk);
    check_idle("R10");
    for (int i = 0; i < NVEC; i++) begin
      logic [1:0] v_cl; logic v_fp; logic [9:0] v_nb; logic v_pa;
      logic [1:0] v_bk; logic [12:0] v_row; logic [8:0] v_col;
      {v_cl, v_fp, v_nb, v_pa, v_bk, v_row, v_col} = VEC[i];
      run_req(v_cl, v_fp, v_nb, v_pa, v_bk, v_row, v_col);
    end
    // R6: longest full page burst, CL2
    run_req(2'd2, 1'b1, 10'd512, 1'b0, 2'd3, 13'h0055, 9'h000);
    // R5: fixed mode with count above page size still clamps to four
    run_req(2'd1, 1'b0, 10'd1000, 1'b1, 2'd2, 13'h0066, 9'h008);
    // R10: reset in the middle of a full page burst
    while (req_ready !== 1'b1) @(negedge clk);
    cas_lat = 2'd3; req_fp = 1'b1; req_beats = 10'd50; req_pa = 1'b0;
    req_bank = 2'd1; req_row = 13'h0321; req_col = 9'h004; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    repeat (8) @(negedge clk);
    chk(rd_valid == 1'b1, "R10", "mid burst valid", int'(rd_valid), 1);
    rst = 1'b1;
    @(negedge clk);
    check_idle("R10");
    rst = 1'b0;
    @(negedge clk);
    check_idle("R10");
    repeat (4) begin
      @(negedge clk);
      chk(cmd == 4'b0111, "R1", "quiet nop", int'(cmd), 7);
    end
    // recovery after abandoned burst
    run_req(2'd3, 1'b0, 10'd2, 1'b1, 2'd0, 13'h0999, 9'h0C0);
    finished = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule